// File: doc/BRIEF.md
# Preload-Terminated Up Counter with Decimal Display

This block is a 6-bit up counter that starts at zero and advances by one on each clock edge while its enable input is high. A 6-bit limit input sets the value at which counting ends. When the count reaches the limit, or the limit falls below the count, the counter freezes and a done flag goes high. The counter stays frozen and the flag stays high until a synchronous reset.

The block also shows the limit value in decimal on two seven-segment digits, one for tens and one for units. The segment drive is active low and the decimal point is held dark. The block suits event counting and timed control strobes where software or switches set the terminal count.

Top module: `limit_counter`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, the count becomes 0 and `done` becomes 0 on that edge.
- R2: When `done` is low and `en` is high at a rising edge, the count increments by one. When `en` is low, the count holds.
- R3: `done` becomes high on the first edge at which the count, before that edge, is greater than or equal to `limit`. The count does not advance on that edge.
- R4: Once `done` is high, the count and `done` hold until reset, whatever `en` and `limit` do.
- R5: With `limit` equal to 0, `done` rises on the first edge after reset and the count stays at 0.
- R6: If `limit` changes to a value below the current count, `done` rises on the next edge and counting stops.
- R7: The tens digit shows `limit/10` and the units digit shows `limit%10`. This output is combinational from `limit`.
- R8: Segment outputs are active low. The bit order is {dp,g,f,e,d,c,b,a}, so bit 0 is segment a and bit 7 is the decimal point. The decimal point bit is always 1 (dark). Digit codes, written as bits 6..0 active high, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable |
| limit | input | 6 | Terminal count value |
| count | output | 6 | Current count |
| done | output | 1 | End flag |
| seg_tens | output | 8 | Tens digit segments, active low |
| seg_units | output | 8 | Units digit segments, active low |

## Verification
The only state in the block is the count register and the done flag, and both are visible at the ports. A wrong increment, hold or stop decision therefore shows on `count` or `done` in the cycle right after the faulty edge. The bench compares both outputs against a behavioural model after every edge, so a mistake is caught within one cycle. The display path holds no state, so a wrong digit split or segment code shows as soon as `limit` is applied. The bench checks all 64 limit values for this.

// File: rtl/limit_counter.sv
module limit_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         done,
  output logic [7:0]   seg_tens,
  output logic [7:0]   seg_units
);
  logic hit;
  assign hit = (count >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (hit) done <= 1'b1;
      else if (en) count <= count + 1'b1;
    end
  end

  function automatic logic [6:0] seg_code(input int d);
    case (d)
      0: seg_code = 7'h3F; 1: seg_code = 7'h06; 2: seg_code = 7'h5B;
      3: seg_code = 7'h4F; 4: seg_code = 7'h66; 5: seg_code = 7'h6D;
      6: seg_code = 7'h7D; 7: seg_code = 7'h07; 8: seg_code = 7'h7F;
      9: seg_code = 7'h6F; default: seg_code = 7'h00;
    endcase
  endfunction

  int lim_i;
  assign lim_i     = int'(limit);
  assign seg_tens  = {1'b1, ~seg_code((lim_i / 10) % 10)};
  assign seg_units = {1'b1, ~seg_code(lim_i % 10)};

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (count == '0 && !done));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !done) |=> $stable(count));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(count)));
  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && count >= limit) |=> (done && $stable(count)));
  // R8
  dp_dark_chk: assert property (@(posedge clk) seg_tens[7] && seg_units[7]);
endmodule

// File: tb/limit_counter_tb.sv
module limit_counter_tb_top;
  logic clk = 0, rst_n = 0, en = 0;
  logic [5:0] limit = 0;
  logic [5:0] count;
  logic done;
  logic [7:0] seg_tens, seg_units;
  int checks = 0, fails = 0;
  int m_cnt = 0;
  bit m_done = 0;

  always #2 clk = ~clk;

  limit_counter dut_i (.clk(clk), .rst_n(rst_n), .en(en), .limit(limit),
    .count(count), .done(done), .seg_tens(seg_tens), .seg_units(seg_units));

  function automatic logic [7:0] exp_seg(input int d);
    int pat[10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
    logic [7:0] p;
    p = 8'(pat[d]);
    return {1'b1, ~p[6:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model step then compare mid-cycle
  task automatic step(string req);
    @(posedge clk);
    if (!rst_n) begin m_cnt = 0; m_done = 0; end
    else if (!m_done) begin
      if (m_cnt >= int'(limit)) m_done = 1;
      else if (en) m_cnt++;
    end
    #1;
    chk({req, " count"}, int'(count), m_cnt);
    chk({req, " done"}, int'(done), int'(m_done));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step("R1"); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R7 R8 display across all limits
    for (int v = 0; v < 64; v++) begin
      limit = 6'(v); #1;
      chk("R7 tens", int'(seg_tens), int'(exp_seg(v / 10)));
      chk("R8 units", int'(seg_units), int'(exp_seg(v % 10)));
    end
    limit = 6'd53; #1;
    chk("R7 53 tens", int'(seg_tens), int'(exp_seg(5)));
    chk("R7 53 units", int'(seg_units), int'(exp_seg(3)));
    // R1 reset
    do_reset();
    // R2 count with gaps in enable, then R3 stop at 10
    limit = 6'd10;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); en = (i % 3 != 1);
      step("R2/R3");
    end
    chk("R3 final", int'(count), 10);
    // R4 sticky done despite limit change
    @(negedge clk); limit = 6'd63; en = 1;
    for (int i = 0; i < 5; i++) step("R4");
    // R5 limit zero
    @(negedge clk); limit = 0; do_reset();
    for (int i = 0; i < 4; i++) step("R5");
    chk("R5 count", int'(count), 0);
    // R6 limit lowered below count
    @(negedge clk); limit = 6'd40; do_reset(); en = 1;
    for (int i = 0; i < 20; i++) step("R6 pre");
    @(negedge clk); limit = 6'd5;
    for (int i = 0; i < 4; i++) step("R6");
    chk("R6 done", int'(done), 1);
    // R1 reset mid count
    @(negedge clk); limit = 6'd63; do_reset();
    for (int i = 0; i < 7; i++) step("R2 run");
    @(negedge clk); rst_n = 0; step("R1 mid"); @(negedge clk); rst_n = 1;
    // full-scale run
    for (int i = 0; i < 70; i++) step("R3 full");
    chk("R3 full count", int'(count), 63);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule